// File: doc/BRIEF.md
# Boot-Chip Command-Addressed Slave Device

This block is a slave on an expansion bus. The bus controller drives it with single-cycle immediate transfers. After the device is selected, the first immediate write is taken as a command word. That word sets an internal pointer. Later immediate reads and writes act on whatever the pointer decodes to: a seconds counter, a small battery-backed byte store, or a debug character output window.

The pointer holds the byte address in a field that starts at bit 6. After each access to the byte store, the pointer moves forward by the byte count shifted left by that amount. Read data comes back on a registered port one cycle after the read strobe. Characters written into the output window appear as per-lane valid strobes, together with a per-lane end-of-line flag. The seconds counter increments on a one-pulse-per-second input and can be preset through a load port.

Top module: `bootdev`

## Requirements
- R1: While `select` is high, the first write after `select` was last low, or after reset, is captured as the command word and stored as the pointer; a word below 0x20000000 is shifted right by 6 before it is stored. Later writes are data writes.
- R2: Bit 31 of the pointer is ignored when decoding the target.
- R3: A read with the pointer at 0x20000000 returns the 32-bit seconds counter. The counter adds 1 on each `ppsTick` cycle. `rtcLoad` presets it to `rtcLoadValue`, and a load wins over a tick in the same cycle.
- R4: `rdValid` pulses and `rdData` updates one cycle after a read strobe. A read of the store returns the first byte in bits 31:24, the next byte in 23:16 and so on; the unused low bytes are zero. The length code values 0 to 3 select 1 to 4 bytes.
- R5: The store is 64 bytes, mapped from 0x20000100 to 0x200010FF. The byte index is ((pointer >> 6) & 0xFF) - 4, taken modulo 64.
- R6: Each store read or store write advances the pointer by (byte count << 6). Counter reads and window accesses leave the pointer unchanged.
- R7: A store write puts bits 31:24 at the indexed byte and the following bytes at the next indices, wrapping modulo 64.
- R8: A read with the pointer exactly at 0x20010000 returns 0x03000000.
- R9: A write with the pointer in 0x20010000 to 0x200100FF emits its bytes one cycle later on `uartData`. Lane 3 (bits 31:24) carries the first character, and `uartLanes` marks the valid lanes from lane 3 downward. `uartEol` flags each valid lane whose byte equals 13.
- R10: Reads from undecoded pointers return zero with `rdValid`, and writes to them change nothing. Transfers while `select` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| select | input | 1 | Device select; a low level re-arms command capture |
| xferValid | input | 1 | One-cycle immediate transfer strobe |
| xferWrite | input | 1 | 1 = write, 0 = read |
| xferLen | input | 2 | Byte count minus one |
| xferWdata | input | 32 | Write data / command word |
| ppsTick | input | 1 | One pulse per second |
| rtcLoad | input | 1 | Preset strobe for the seconds counter |
| rtcLoadValue | input | 32 | Preset value |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 32 | Read data |
| uartLanes | output | 4 | Valid character lanes |
| uartData | output | 32 | Character bytes |
| uartEol | output | 4 | Lane holds a line-end byte |

## Verification
Read data and character strobes are due exactly one clock after the edge that takes the transfer. Pointer moves and store writes take effect in time for the very next transfer. The bench changes inputs on the falling edge and holds each strobe for one cycle. It samples outputs at the next falling edge, which is the point where each registered result first appears. Chains of transfers then show that the pointer advanced by the correct amount.

// File: rtl/bootdev_pkg.sv
package bootdev_pkg;

  typedef struct packed {
    logic       rtcRead;
    logic       sramRead;
    logic       sramWrite;
    logic       uartRead;
    logic       uartWrite;
    logic       nullRead;
    logic [2:0] nBytes;
  } devStrobe_t;

endpackage

// File: rtl/bootdev_ctrl.sv
module bootdev_ctrl
  import bootdev_pkg::*;
#(
  parameter int          ADDR_SHIFT = 6,
  parameter int          SRAM_BYTES = 64,
  parameter int          UART_SPAN  = 256,
  parameter logic [31:0] RTC_ADDR   = 32'h2000_0000,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0100,
  parameter logic [31:0] UART_BASE  = 32'h2001_0000,
  parameter logic [31:0] SHIFT_LIM  = 32'h2000_0000,
  localparam int         IDX_W      = $clog2(SRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              select,
  input  logic              xferValid,
  input  logic              xferWrite,
  input  logic [1:0]        xferLen,
  input  logic [31:0]       xferWdata,
  output devStrobe_t        strobe,
  output logic [IDX_W-1:0]  sramIdx
);

  localparam logic [31:0] SRAM_END  = SRAM_BASE + (32'(SRAM_BYTES) << ADDR_SHIFT);
  localparam logic [31:0] UART_END  = UART_BASE + 32'(UART_SPAN);
  localparam logic [7:0]  FIRST_IDX = 8'((SRAM_BASE >> ADDR_SHIFT) & 32'hFF);

  logic        firstPending;
  logic [31:0] ptr;
  logic [31:0] decAddr;
  logic [2:0]  nBytes;
  logic        cmdCapture, readPhase, writePhase;
  logic        inRtc, inSram, inUartRd, inUartWin;
  logic [7:0]  winIdx;

  assign nBytes     = {1'b0, xferLen} + 3'd1;
  assign cmdCapture = select & xferValid & xferWrite & firstPending;
  assign writePhase = select & xferValid & xferWrite & ~firstPending;
  assign readPhase  = select & xferValid & ~xferWrite;

  assign decAddr   = {1'b0, ptr[30:0]};
  assign inRtc     = (decAddr == RTC_ADDR);
  assign inSram    = (decAddr >= SRAM_BASE) && (decAddr < SRAM_END);
  assign inUartRd  = (decAddr == UART_BASE);
  assign inUartWin = (decAddr >= UART_BASE) && (decAddr < UART_END);

  assign winIdx  = ptr[ADDR_SHIFT+7:ADDR_SHIFT] - FIRST_IDX;
  assign sramIdx = winIdx[IDX_W-1:0];

  always_comb begin
    strobe        = '0;
    strobe.nBytes = nBytes;
    if (readPhase) begin
      strobe.rtcRead  = inRtc;
      strobe.sramRead = inSram;
      strobe.uartRead = inUartRd;
      strobe.nullRead = ~(inRtc | inSram | inUartRd);
    end else if (writePhase) begin
      strobe.sramWrite = inSram;
      strobe.uartWrite = inUartWin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPending <= 1'b1;
      ptr          <= '0;
    end else if (!select) begin
      firstPending <= 1'b1;
    end else if (cmdCapture) begin
      firstPending <= 1'b0;
      ptr          <= (xferWdata < SHIFT_LIM) ? (xferWdata >> ADDR_SHIFT) : xferWdata;
    end else if (strobe.sramRead || strobe.sramWrite) begin
      ptr <= ptr + (32'(nBytes) << ADDR_SHIFT);
    end
  end

  // R1: once a command is taken, the next write is data
  a_r1_capture_once: assert property (@(posedge clk) disable iff (!rstN)
    cmdCapture |=> !firstPending);

  // R6: a store access moves the pointer by the byte count in the address field
  a_r6_ptr_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sramRead || strobe.sramWrite) |=>
      ptr == $past(ptr) + (32'($past(strobe.nBytes)) << ADDR_SHIFT));

  // R6: counter reads leave the pointer where it was
  a_r6_rtc_no_move: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rtcRead |=> $stable(ptr));

endmodule

// File: rtl/bootdev_datapath.sv
module bootdev_datapath
  import bootdev_pkg::*;
#(
  parameter int          SRAM_BYTES = 64,
  parameter logic [31:0] UART_STATUS = 32'h0300_0000,
  localparam int         IDX_W = $clog2(SRAM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  devStrobe_t       strobe,
  input  logic [IDX_W-1:0] sramIdx,
  input  logic [31:0]      xferWdata,
  input  logic             ppsTick,
  input  logic             rtcLoad,
  input  logic [31:0]      rtcLoadValue,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic [3:0]       uartLanes,
  output logic [31:0]      uartData,
  output logic [3:0]       uartEol
);

  localparam int LANES = 4;

  logic [31:0] rtcCount;
  logic [7:0]  mem [SRAM_BYTES];
  logic [3:0]  laneOn;
  logic [31:0] sramWord;
  logic [3:0]  laneEol;
  logic        anyRead;

  // lane k holds bits 8k+7:8k; lane 3 is the first byte in order
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int ORD = LANES - 1 - k;
    assign laneOn[k] = (32'(strobe.nBytes) > ORD);
    assign sramWord[8*k +: 8] = laneOn[k] ? mem[IDX_W'(32'(sramIdx) + ORD)] : 8'h00;
    assign laneEol[k] = laneOn[k] && (xferWdata[8*k +: 8] == 8'd13);
  end

  assign anyRead = strobe.rtcRead | strobe.sramRead | strobe.uartRead | strobe.nullRead;

  always_ff @(posedge clk) begin
    if (!rstN)        rtcCount <= '0;
    else if (rtcLoad) rtcCount <= rtcLoadValue;
    else if (ppsTick) rtcCount <= rtcCount + 32'd1;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++) begin
      if (strobe.sramWrite && (32'(strobe.nBytes) > j))
        mem[IDX_W'(32'(sramIdx) + j)] <= xferWdata[31-8*j -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= anyRead;
      if (strobe.rtcRead)       rdData <= rtcCount;
      else if (strobe.sramRead) rdData <= sramWord;
      else if (strobe.uartRead) rdData <= UART_STATUS;
      else if (strobe.nullRead) rdData <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uartLanes <= '0;
      uartData  <= '0;
      uartEol   <= '0;
    end else if (strobe.uartWrite) begin
      uartLanes <= laneOn;
      uartData  <= xferWdata;
      uartEol   <= laneEol;
    end else begin
      uartLanes <= '0;
      uartEol   <= '0;
    end
  end

  // R10: the control decodes at most one target per transfer
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rtcRead, strobe.sramRead, strobe.sramWrite,
              strobe.uartRead, strobe.uartWrite, strobe.nullRead}));

  // R4: read data is due one cycle after the read strobe, never otherwise
  a_r4_rd_due: assert property (@(posedge clk) disable iff (!rstN)
    anyRead |=> rdValid);
  a_r4_rd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |=> !rdValid);

  // R3: preset wins over tick
  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    rtcLoad |=> rtcCount == $past(rtcLoadValue));
  a_r3_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!rtcLoad && ppsTick) |=> rtcCount == $past(rtcCount) + 32'd1);

  // R9: lanes fill from lane 3 downward and line ends sit on valid lanes
  a_r9_lane_shape: assert property (@(posedge clk) disable iff (!rstN)
    uartLanes == 4'b0000 || uartLanes == 4'b1000 || uartLanes == 4'b1100 ||
    uartLanes == 4'b1110 || uartLanes == 4'b1111);
  a_r9_eol_in_lane: assert property (@(posedge clk) disable iff (!rstN)
    (uartEol & ~uartLanes) == 4'b0000);

endmodule

// File: rtl/bootdev.sv
module bootdev
  import bootdev_pkg::*;
#(
  parameter int          ADDR_SHIFT  = 6,
  parameter int          SRAM_BYTES  = 64,
  parameter int          UART_SPAN   = 256,
  parameter logic [31:0] RTC_ADDR    = 32'h2000_0000,
  parameter logic [31:0] SRAM_BASE   = 32'h2000_0100,
  parameter logic [31:0] UART_BASE   = 32'h2001_0000,
  parameter logic [31:0] UART_STATUS = 32'h0300_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        select,
  input  logic        xferValid,
  input  logic        xferWrite,
  input  logic [1:0]  xferLen,
  input  logic [31:0] xferWdata,
  input  logic        ppsTick,
  input  logic        rtcLoad,
  input  logic [31:0] rtcLoadValue,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic [3:0]  uartLanes,
  output logic [31:0] uartData,
  output logic [3:0]  uartEol
);

  localparam int IDX_W = $clog2(SRAM_BYTES);

  devStrobe_t       strobe;
  logic [IDX_W-1:0] sramIdx;

  bootdev_ctrl #(
    .ADDR_SHIFT(ADDR_SHIFT), .SRAM_BYTES(SRAM_BYTES), .UART_SPAN(UART_SPAN),
    .RTC_ADDR(RTC_ADDR), .SRAM_BASE(SRAM_BASE), .UART_BASE(UART_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .select(select), .xferValid(xferValid),
    .xferWrite(xferWrite), .xferLen(xferLen), .xferWdata(xferWdata),
    .strobe(strobe), .sramIdx(sramIdx)
  );

  bootdev_datapath #(
    .SRAM_BYTES(SRAM_BYTES), .UART_STATUS(UART_STATUS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sramIdx(sramIdx),
    .xferWdata(xferWdata), .ppsTick(ppsTick), .rtcLoad(rtcLoad),
    .rtcLoadValue(rtcLoadValue), .rdValid(rdValid), .rdData(rdData),
    .uartLanes(uartLanes), .uartData(uartData), .uartEol(uartEol)
  );

endmodule

// File: tb/bootdev_test.sv
module bootdev_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        select = 1'b0;
  logic        xferValid = 1'b0;
  logic        xferWrite = 1'b0;
  logic [1:0]  xferLen = '0;
  logic [31:0] xferWdata = '0;
  logic        ppsTick = 1'b0;
  logic        rtcLoad = 1'b0;
  logic [31:0] rtcLoadValue = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic [3:0]  uartLanes;
  logic [31:0] uartData;
  logic [3:0]  uartEol;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bootdev uut (
    .clk(clk), .rstN(rstN), .select(select), .xferValid(xferValid),
    .xferWrite(xferWrite), .xferLen(xferLen), .xferWdata(xferWdata),
    .ppsTick(ppsTick), .rtcLoad(rtcLoad), .rtcLoadValue(rtcLoadValue),
    .rdValid(rdValid), .rdData(rdData), .uartLanes(uartLanes),
    .uartData(uartData), .uartEol(uartEol)
  );

  // kind: 0 = reselect + command, 1 = data write, 2 = read and compare
  localparam int NV = 13;
  localparam logic [67:0] VEC [NV] = '{
    {2'd0, 2'd0, 32'h2000_0100, 32'h0},
    {2'd1, 2'd3, 32'h1122_3344, 32'h0},
    {2'd1, 2'd1, 32'hAABB_0000, 32'h0},
    {2'd0, 2'd0, 32'h2000_0100, 32'h0},
    {2'd2, 2'd3, 32'h0,         32'h1122_3344},
    {2'd2, 2'd0, 32'h0,         32'hAA00_0000},
    {2'd2, 2'd0, 32'h0,         32'hBB00_0000},
    {2'd0, 2'd0, 32'h2000_0140, 32'h0},
    {2'd2, 2'd2, 32'h0,         32'h2233_4400},
    {2'd0, 2'd0, 32'hA000_0100, 32'h0},
    {2'd2, 2'd0, 32'h0,         32'h1100_0000},
    {2'd0, 2'd0, 32'h0000_0100, 32'h0},
    {2'd2, 2'd3, 32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] len, input logic [31:0] d);
    @(negedge clk);
    xferWrite = wr; xferLen = len; xferWdata = d; xferValid = 1'b1;
    @(negedge clk);
    xferValid = 1'b0;
  endtask

  task automatic command(input logic [31:0] w);
    @(negedge clk) select = 1'b0;
    @(negedge clk) select = 1'b1;
    xfer(1'b1, 2'd0, w);
  endtask

  task automatic readCheck(input string req, input logic [1:0] len, input logic [31:0] exp);
    xfer(1'b0, len, 32'h0);
    check(req, {31'b0, rdValid}, 32'h1);
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    check("R4 reset rdValid", {31'b0, rdValid}, 32'h0);
    check("R4 reset rdData", rdData, 32'h0);
    check("R9 reset lanes", {28'b0, uartLanes}, 32'h0);

    // vector table: store writes/reads, index math, pointer advance (R1 R2 R5 R6 R7 R10)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][67:66])
        2'd0: command(VEC[i][63:32]);
        2'd1: xfer(1'b1, VEC[i][65:64], VEC[i][63:32]);
        default: readCheck($sformatf("R5 vector %0d", i), VEC[i][65:64], VEC[i][31:0]);
      endcase
    end

    // R3 preset, ticks, no pointer move on counter read (R6)
    @(negedge clk) begin rtcLoad = 1'b1; rtcLoadValue = 32'h1234_5678; end
    @(negedge clk) rtcLoad = 1'b0;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk) ppsTick = 1'b1;
      @(negedge clk) ppsTick = 1'b0;
    end
    command(32'h2000_0000);
    readCheck("R3 counter", 2'd3, 32'h1234_567B);
    readCheck("R6 counter read keeps pointer", 2'd3, 32'h1234_567B);
    @(negedge clk) begin rtcLoad = 1'b1; ppsTick = 1'b1; rtcLoadValue = 32'h0000_0100; end
    @(negedge clk) begin rtcLoad = 1'b0; ppsTick = 1'b0; end
    readCheck("R3 load beats tick", 2'd3, 32'h0000_0100);

    // R8 status read, R10 non-base window read
    command(32'h2001_0000);
    readCheck("R8 status", 2'd3, 32'h0300_0000);
    command(32'h2001_0040);
    readCheck("R10 window off-base read", 2'd3, 32'h0);

    // R9 character output
    command(32'h2001_0000);
    xfer(1'b1, 2'd3, 32'h4869_0D0A);
    check("R9 lanes four", {28'b0, uartLanes}, 32'hF);
    check("R9 data", uartData, 32'h4869_0D0A);
    check("R9 eol lane1", {28'b0, uartEol}, 32'h2);
    xfer(1'b1, 2'd1, 32'h0D42_0000);
    check("R9 lanes two", {28'b0, uartLanes}, 32'hC);
    check("R9 eol lane3", {28'b0, uartEol}, 32'h8);
    command(32'h2001_00C0);
    xfer(1'b1, 2'd0, 32'h4100_0000);
    check("R9 window end lanes", {28'b0, uartLanes}, 32'h8);

    // R7 wrap around the store end
    command(32'h2000_1080);
    xfer(1'b1, 2'd3, 32'hCAFE_F00D);
    command(32'h2000_0100);
    readCheck("R7 wrap low", 2'd1, 32'hF00D_0000);
    command(32'h2000_1080);
    readCheck("R7 wrap high", 2'd1, 32'hCAFE_0000);

    // R10 undecoded write ignored
    command(32'h2000_5000);
    xfer(1'b1, 2'd3, 32'hFFFF_FFFF);
    check("R10 undecoded write no chars", {28'b0, uartLanes}, 32'h0);
    command(32'h2000_0100);
    readCheck("R10 store unchanged", 2'd1, 32'hF00D_0000);

    // R10 transfers with select low are ignored; R1 reselect rearms capture
    command(32'h2000_0100);
    @(negedge clk) select = 1'b0;
    xfer(1'b0, 2'd3, 32'h0);
    check("R10 deselected read", {31'b0, rdValid}, 32'h0);
    xfer(1'b1, 2'd3, 32'h5555_5555);
    @(negedge clk) select = 1'b1;
    xfer(1'b1, 2'd0, 32'h2000_0100);
    readCheck("R1 recapture after deselect", 2'd1, 32'hF00D_0000);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule